// File: doc/BRIEF.md
# Power-Fail Clock, Reset and Write Guard

This block keeps a processor and its battery-backed program RAM safe while the main supply rises and falls. A digital power-good bit stands in for the supply comparator. When power-good drops, the processor clock enable and the processor reset go inactive/active at once, with no clock edge in the path. Both RAM strobes are forced inactive, so a write cannot land in the non-volatile RAM while the supplies are out of range, even during a dropout of a few milliseconds.

On power-up, power-good is taken through a synchronizer. The clock enable returns only once the synchronized bit is high. A cycle counter then holds the processor in reset for a programmable number of clock cycles, about one second in the default setting, before it releases it. Any loss of power-good, however short, clears the synchronizer and restarts the count from zero. While power is fully good, the chip-select and write strobes pass straight through a single gate level, so the RAM can be reached with no wait states.

Top module: `pfg_top`

## Requirements
- R1: When `pwr_ok_i` goes low, `clk_en_o` goes low in the same instant, with no clock edge needed, and stays low while `pwr_ok_i` is low.
- R2: `cpu_rst_n_o` is low (reset asserted) whenever `clk_en_o` is low.
- R3: After `pwr_ok_i` rises and stays high, `clk_en_o` rises just after the second rising clock edge (two-stage synchronizer, `SYNC_STAGES` = 2).
- R4: `cpu_rst_n_o` rises just after the `RST_DELAY_CYC`-th rising clock edge counted from the edge at which `clk_en_o` rose, provided power stays good.
- R5: Any low pulse on `pwr_ok_i` clears the synchronizer and the reset count. This holds even for a pulse that falls and recovers between two clock edges. After such a pulse, R3 and R4 apply again from the recovery.
- R6: `ram_cs_n_o` is high (inactive) whenever `clk_en_o` is low, whatever the value of `ram_cs_n_i`.
- R7: `ram_we_n_o` is high (inactive) whenever `clk_en_o` is low, whatever the value of `ram_we_n_i`.
- R8: While `clk_en_o` is high, `ram_cs_n_o` equals `ram_cs_n_i` and `ram_we_n_o` equals `ram_we_n_i` within the same cycle, with no register in the path.
- R9: While `rst_n_i` is low, `clk_en_o` is low, `cpu_rst_n_o` is low and both RAM strobes are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Chip reset, active low, asynchronous assert, released in step with the clock |
| pwr_ok_i | input | 1 | Power-good from the supply monitor, asynchronous, high when the slowest supply is at full value |
| ram_cs_n_i | input | 1 | Processor chip-select for the program RAM, active low |
| ram_we_n_i | input | 1 | Processor write strobe for the program RAM, active low |
| clk_en_o | output | 1 | Processor clock enable, high when power is fully good |
| cpu_rst_n_o | output | 1 | Processor reset, active low |
| ram_cs_n_o | output | 1 | Guarded chip-select to the RAM, active low |
| ram_we_n_o | output | 1 | Guarded write strobe to the RAM, active low |

## Verification
The gated strobes and the falling clock enable are combinational. They are due in the same cycle as their cause, so the bench checks them 1 ns after each input change, and also 1 ns after a power-good pulse placed between two edges. A rising clock enable is due after the second edge once power-good is high. A released reset is due after another `RST_DELAY_CYC` edges. A reference model in the bench advances on every rising edge, and all four outputs are compared against it shortly after each falling edge, once the new inputs are applied. In this way each registered result is checked in exactly the cycle it should first appear.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    TMR_HOLD  = 2'd0,
    TMR_COUNT = 2'd1,
    TMR_DONE  = 2'd2
  } tmr_state_e;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic clr_n_i,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // Cleared at once when power-good or chip reset goes low; refills one stage per edge.
  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfg_rst_timer.sv
module pfg_rst_timer
  import pfg_pkg::*;
#(
  parameter int DELAY_CYC = 4_000_000
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic stable_i,
  output logic done_o
);
  localparam int CW = cnt_width(DELAY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);
  localparam bit SINGLE = (DELAY_CYC == 1);

  tmr_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      TMR_HOLD: begin
        cnt_en = 1'b1;
        cnt_d  = '0;
        if (stable_i) begin
          if (SINGLE) state_d = TMR_DONE;
          else begin
            state_d = TMR_COUNT;
            cnt_d   = CW'(1);
          end
        end
      end
      TMR_COUNT: begin
        cnt_en = 1'b1;
        if (!stable_i) begin
          state_d = TMR_HOLD;
          cnt_d   = '0;
        end else if (cnt_q == LAST) begin
          state_d = TMR_DONE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      TMR_DONE: begin
        if (!stable_i) begin
          state_d = TMR_HOLD;
          cnt_en  = 1'b1;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = TMR_HOLD;
        cnt_en  = 1'b1;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) state_q <= TMR_HOLD;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (state_q == TMR_DONE);
endmodule

// File: rtl/pfg_strobe_gate.sv
module pfg_strobe_gate #(
  parameter int N_STROBE = 2
) (
  input  logic                allow_i,
  input  logic [N_STROBE-1:0] strobe_n_i,
  output logic [N_STROBE-1:0] strobe_n_o
);
  // One OR level per strobe: a low strobe reaches the RAM only when allowed.
  for (genvar g = 0; g < N_STROBE; g++) begin : g_gate
    assign strobe_n_o[g] = strobe_n_i[g] | ~allow_i;
  end
endmodule

// File: rtl/pfg_top.sv
module pfg_top #(
  parameter int RST_DELAY_CYC = 4_000_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pwr_ok_i,
  input  logic ram_cs_n_i,
  input  logic ram_we_n_i,
  output logic clk_en_o,
  output logic cpu_rst_n_o,
  output logic ram_cs_n_o,
  output logic ram_we_n_o
);
  localparam int N_STROBE = 2;

  logic sync_clr_n;
  logic pwr_stable;
  logic pwr_full;
  logic timer_done;
  logic [N_STROBE-1:0] strobe_in;
  logic [N_STROBE-1:0] strobe_out;

  assign sync_clr_n = rst_n_i & pwr_ok_i;

  pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .clr_n_i (sync_clr_n),
    .level_o (pwr_stable)
  );

  // Raw power-good term keeps the drop path free of any register.
  assign pwr_full = pwr_ok_i & pwr_stable;

  pfg_rst_timer #(.DELAY_CYC(RST_DELAY_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .stable_i (pwr_stable),
    .done_o   (timer_done)
  );

  assign strobe_in = {ram_we_n_i, ram_cs_n_i};

  pfg_strobe_gate #(.N_STROBE(N_STROBE)) u_gate (
    .allow_i    (pwr_full),
    .strobe_n_i (strobe_in),
    .strobe_n_o (strobe_out)
  );

  assign clk_en_o    = pwr_full;
  assign cpu_rst_n_o = timer_done & pwr_full;
  assign ram_cs_n_o  = strobe_out[0];
  assign ram_we_n_o  = strobe_out[1];
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int RST_DELAY_CYC = 4_000_000
) (
  input logic clk_i,
  input logic rst_n_i,
  input logic pwr_ok_i,
  input logic ram_cs_n_i,
  input logic ram_we_n_i,
  input logic clk_en_o,
  input logic cpu_rst_n_o,
  input logic ram_cs_n_o,
  input logic ram_we_n_o
);
  localparam int CW = pfg_pkg::cnt_width(RST_DELAY_CYC + 1);
  logic [CW-1:0] on_cnt;

  // Number of sampled edges with the clock enabled, saturating past the delay.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)                          on_cnt <= '0;
    else if (!clk_en_o)                    on_cnt <= '0;
    else if (on_cnt <= CW'(RST_DELAY_CYC)) on_cnt <= on_cnt + CW'(1);
  end

  p_clk_off_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !pwr_ok_i |-> !clk_en_o);
  p_rst_held_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !clk_en_o |-> !cpu_rst_n_o);
  p_en_after_good_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clk_en_o |-> $past(pwr_ok_i));
  p_release_delay_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(cpu_rst_n_o) |-> (on_cnt == CW'(RST_DELAY_CYC)));
  p_cs_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !clk_en_o |-> ram_cs_n_o);
  p_we_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !clk_en_o |-> ram_we_n_o);
  p_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clk_en_o |-> (ram_cs_n_o == ram_cs_n_i) && (ram_we_n_o == ram_we_n_i));
endmodule

bind pfg_top pfg_checker #(.RST_DELAY_CYC(RST_DELAY_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .pwr_ok_i    (pwr_ok_i),
  .ram_cs_n_i  (ram_cs_n_i),
  .ram_we_n_i  (ram_we_n_i),
  .clk_en_o    (clk_en_o),
  .cpu_rst_n_o (cpu_rst_n_o),
  .ram_cs_n_o  (ram_cs_n_o),
  .ram_we_n_o  (ram_we_n_o)
);

// File: tb/pfg_top_test.sv
module pfg_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DELAY      = 12;

  logic clk = 1'b0;
  logic rst_n, pwr_ok, cs_n, we_n;
  logic clk_en, cpu_rst_n, cs_n_o, we_n_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // Reference model state
  bit m_s1, m_s2, m_rel;
  int m_cnt;

  pfg_top #(.RST_DELAY_CYC(DELAY), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_n_i(rst_n), .pwr_ok_i(pwr_ok),
    .ram_cs_n_i(cs_n), .ram_we_n_i(we_n),
    .clk_en_o(clk_en), .cpu_rst_n_o(cpu_rst_n),
    .ram_cs_n_o(cs_n_o), .ram_we_n_o(we_n_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_cnt = 0; m_rel = 0;
    end else begin
      bit stable;
      stable = m_s2;
      if (pwr_ok) begin m_s2 = m_s1; m_s1 = 1; end
      if (!stable) begin m_cnt = 0; m_rel = 0; end
      else if (!m_rel) begin
        m_cnt++;
        if (m_cnt == DELAY) m_rel = 1;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic en_e;
    en_e = rst_n & pwr_ok & m_s2;
    chk(clk_en,    en_e,               "R1 R3 clk_en");
    chk(cpu_rst_n, en_e & m_rel,       "R2 R4 R5 cpu_rst_n");
    chk(cs_n_o,    cs_n | ~en_e,       "R6 R8 ram_cs_n");
    chk(we_n_o,    we_n | ~en_e,       "R7 R8 ram_we_n");
  endtask

  task automatic set_pwr(input logic v);
    pwr_ok = v;
    if (!v) begin m_s1 = 0; m_s2 = 0; end
  endtask

  task automatic cycle(input logic p, input logic c, input logic w);
    @(negedge clk);
    set_pwr(p); cs_n = c; we_n = w;
    #1 compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pwr_ok = 1; cs_n = 0; we_n = 0;
    // R9: chip reset holds everything off even with power good and strobes low
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(clk_en, 1'b0, "R9 clk_en in reset");
      chk(cpu_rst_n, 1'b0, "R9 cpu_rst_n in reset");
      chk(cs_n_o, 1'b1, "R9 ram_cs_n in reset");
      chk(we_n_o, 1'b1, "R9 ram_we_n in reset");
    end
    @(negedge clk); rst_n = 1; set_pwr(0);
    // Power off, processor attempting writes: R6 R7
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 1'b0);
    // Power-up with strobe patterns: R3 R4 R8
    for (int i = 0; i < DELAY + 6; i++) cycle(1'b1, i[0], i[1]);
    // R1: drop between edges, check with no clock edge in between
    @(negedge clk); cs_n = 0; we_n = 0; #1 compare_all();
    #1 set_pwr(0); #1;
    chk(clk_en, 1'b0, "R1 immediate drop");
    chk(cpu_rst_n, 1'b0, "R2 immediate reset");
    chk(we_n_o, 1'b1, "R7 immediate write block");
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 1'b0);
    // Recover, then a multi-cycle dropout mid-count: R5
    for (int i = 0; i < DELAY / 2; i++) cycle(1'b1, i[0], 1'b1);
    for (int i = 0; i < 2; i++) cycle(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < DELAY / 2 + 2; i++) cycle(1'b1, 1'b1, i[0]);
    // R5: short pulse between two edges during the count
    @(negedge clk); #1 set_pwr(0); #1;
    chk(clk_en, 1'b0, "R5 glitch drop");
    chk(cs_n_o, 1'b1, "R6 glitch block");
    #1 set_pwr(1); #1 compare_all();
    for (int i = 0; i < DELAY + 6; i++) cycle(1'b1, i[1], i[0]);
    // Dropout after release with a write attempt
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < DELAY + 4; i++) cycle(1'b1, 1'b0, i[0]);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule